// File: doc/BRIEF.md
# Reorder-Buffer Head Stall Interference Accumulator

This per-core block converts memory-side miss events into cycles of lost progress caused by other cores. It holds a mark bit for every reorder-buffer entry, set when the load in that entry is a sampled miss that another core's activity caused. It also holds a saturating waiting-cycle counter for every miss-status entry, which gathers the contention cycles that the memory side reports for that outstanding access. Two 32-bit accumulators are the outputs: a marked-load penalty counter and a total interference counter.

Cycles are charged only while the core is truly stalled. This means the head entry is waiting on a long-latency load and one of three conditions holds: the reorder buffer is full, the issue queue is full, or no rename register is free. Waiting cycles stay buffered in the miss entry until that miss blocks the head. They are then moved into the total in one step, and any further pulses pass straight through. A miss that never blocks the head loses its buffered cycles when its entry is allocated again or freed. Software reads both accumulators once per timeslice and clears them with a one-cycle pulse.

Top module: `rob_stall_charge`

## Requirements
- R1: After reset, `total_cycles` and `marked_cycles` are 0, every mark bit is clear and every waiting counter is 0.
- R2: The blocking condition is `rob_full | iq_full | regs_out`. `marked_cycles` rises by exactly 1 in each cycle where this condition holds and the mark bit of entry `head_idx` is set. It does not change when the condition is false or the head entry is unmarked.
- R3: A cycle with `mark_set` high sets the mark bit at `mark_idx`. A cycle with `head_commit` high clears the bit at `head_idx`. `squash_all` clears every bit. A clear wins over a set in the same cycle.
- R4: Each cycle where bit m of `wait_pulse` is high adds 1 to miss entry m's waiting counter. The counter is 10 bits wide and holds at 1023.
- R5: In a blocking cycle with `head_miss` high and `head_mshr` = m, `total_cycles` grows by the buffered count of entry m plus `wait_pulse[m]`. The counter of m is then cleared, so each contention cycle is charged once.
- R6: In a blocking cycle with `head_miss` high, `head_pf_hit` adds 1 more to `total_cycles`. When the condition is false, `head_pf_hit` has no effect.
- R7: `mshr_alloc` or `mshr_free` for entry m clears m's waiting counter, so its buffered cycles are discarded.
- R8: When the blocking condition is false or `head_miss` is low, `total_cycles` does not change.
- R9: A cycle with `sw_clear` high sets both accumulators to 0 and overrides any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rob_full | input | 1 | Reorder buffer has no free entry |
| iq_full | input | 1 | Issue queue has no free slot |
| regs_out | input | 1 | No free rename register |
| head_idx | input | 7 | Index of the oldest reorder-buffer entry |
| head_miss | input | 1 | Head entry is a long-latency load waiting for memory |
| head_mshr | input | 5 | Miss entry serving the head load |
| head_pf_hit | input | 1 | Head load matches a pending prefetch |
| head_commit | input | 1 | Head entry retires this cycle |
| squash_all | input | 1 | Pipeline flush; all entries are discarded |
| mark_set | input | 1 | Sampled directory labels a load as interference-caused |
| mark_idx | input | 7 | Reorder-buffer entry of that load |
| mshr_alloc | input | 1 | A miss entry is allocated |
| mshr_alloc_id | input | 5 | Allocated entry |
| mshr_free | input | 1 | A miss entry is released |
| mshr_free_id | input | 5 | Released entry |
| wait_pulse | input | 32 | One contention cycle per miss entry, bit per entry |
| sw_clear | input | 1 | Timeslice clear of both accumulators |
| total_cycles | output | 32 | Total interference cycles |
| marked_cycles | output | 32 | Penalty cycles of marked head loads |

## Verification
A vector table moves one miss through three phases: buffering, a first transfer, and later blocking cycles. Each of the three stall sources is raised alone, which shows that any one of them is enough to charge cycles. A stall with an unmarked head shows that the penalty count and the waiting-cycle charge are independent. Directed sequences then check what separates a correct design from a near miss: a mark retired by commit or flush, buffered cycles lost on free or allocate, the counter stopping at 1023 rather than wrapping, and a clear beating a same-cycle increment.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int unsigned DEF_ROB_DEPTH = 128;
   localparam int unsigned DEF_MSHR_CNT  = 32;
   localparam int unsigned DEF_WAIT_W    = 10;
   localparam int unsigned DEF_ACC_W     = 32;

   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_ZERO  = 2'd1,
      CNT_STEP  = 2'd2
   } cnt_op_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rsc_mark_array.sv
module rsc_mark_array #(
   parameter int unsigned DEPTH = 128,
   localparam int unsigned IW = rsc_pkg::idx_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          retire_en,
   input  logic [IW-1:0] retire_idx,
   input  logic          flush,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_bit
);
   logic [DEPTH-1:0] marks_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic hit_set, hit_clr;
      assign hit_set = set_en && (set_idx == IW'(e));
      assign hit_clr = flush || (retire_en && (retire_idx == IW'(e)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       marks_q[e] <= 1'b0;
         else if (hit_clr) marks_q[e] <= 1'b0;
         else if (hit_set) marks_q[e] <= 1'b1;
      end
   end

   assign rd_bit = marks_q[rd_idx];
endmodule

// File: rtl/rsc_wait_bank.sv
module rsc_wait_bank #(
   parameter int unsigned ENTRIES  = 32,
   parameter int unsigned CNT_W    = 10,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned IW = rsc_pkg::idx_width(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] pulse,
   input  logic               alloc_en,
   input  logic [IW-1:0]      alloc_id,
   input  logic               free_en,
   input  logic [IW-1:0]      free_id,
   input  logic               drain_en,
   input  logic [IW-1:0]      drain_id,
   output logic [CNT_W-1:0]   drain_val,
   output logic               drain_pulse
);
   import rsc_pkg::*;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
      cnt_op_e          op;
      logic [CNT_W-1:0] nxt_step;

      always_comb begin
         if ((alloc_en && alloc_id == IW'(e)) ||
             (free_en  && free_id  == IW'(e)) ||
             (drain_en && drain_id == IW'(e)))
            op = CNT_ZERO;
         else if (pulse[e])
            op = CNT_STEP;
         else
            op = CNT_HOLD;
      end

      if (SATURATE) begin : g_sat
         assign nxt_step = (cnt_q[e] == CNT_MAX) ? CNT_MAX : cnt_q[e] + 1'b1;
      end else begin : g_wrap
         assign nxt_step = cnt_q[e] + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q[e] <= '0;
         else begin
            case (op)
               CNT_ZERO: cnt_q[e] <= '0;
               CNT_STEP: cnt_q[e] <= nxt_step;
               default:  cnt_q[e] <= cnt_q[e];
            endcase
         end
      end
   end

   assign drain_val   = cnt_q[drain_id];
   assign drain_pulse = pulse[drain_id];
endmodule

// File: rtl/rsc_charge_accum.sv
module rsc_charge_accum #(
   parameter int unsigned ACC_W = 32,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             pen_step,
   input  logic             tot_en,
   input  logic [CNT_W-1:0] buf_val,
   input  logic             live_pulse,
   input  logic             pf_step,
   output logic [ACC_W-1:0] total,
   output logic [ACC_W-1:0] penalty
);
   logic [ACC_W-1:0] tot_q, pen_q, tot_add;

   always_comb begin
      tot_add = '0;
      if (tot_en)
         tot_add = ACC_W'(buf_val) + ACC_W'(live_pulse) + ACC_W'(pf_step);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_q <= '0;
         pen_q <= '0;
      end else if (clear) begin
         tot_q <= '0;
         pen_q <= '0;
      end else begin
         tot_q <= tot_q + tot_add;
         if (pen_step) pen_q <= pen_q + 1'b1;
      end
   end

   assign total   = tot_q;
   assign penalty = pen_q;
endmodule

// File: rtl/rob_stall_charge.sv
module rob_stall_charge #(
   parameter int unsigned ROB_DEPTH = rsc_pkg::DEF_ROB_DEPTH,
   parameter int unsigned MSHR_CNT  = rsc_pkg::DEF_MSHR_CNT,
   parameter int unsigned WAIT_W    = rsc_pkg::DEF_WAIT_W,
   parameter int unsigned ACC_W     = rsc_pkg::DEF_ACC_W,
   parameter bit          WAIT_SAT  = 1'b1,
   localparam int unsigned RIW = rsc_pkg::idx_width(ROB_DEPTH),
   localparam int unsigned MIW = rsc_pkg::idx_width(MSHR_CNT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rob_full,
   input  logic                iq_full,
   input  logic                regs_out,
   input  logic [RIW-1:0]      head_idx,
   input  logic                head_miss,
   input  logic [MIW-1:0]      head_mshr,
   input  logic                head_pf_hit,
   input  logic                head_commit,
   input  logic                squash_all,
   input  logic                mark_set,
   input  logic [RIW-1:0]      mark_idx,
   input  logic                mshr_alloc,
   input  logic [MIW-1:0]      mshr_alloc_id,
   input  logic                mshr_free,
   input  logic [MIW-1:0]      mshr_free_id,
   input  logic [MSHR_CNT-1:0] wait_pulse,
   input  logic                sw_clear,
   output logic [ACC_W-1:0]    total_cycles,
   output logic [ACC_W-1:0]    marked_cycles
);
   if (ROB_DEPTH < 2) begin : g_bad_rob
      $error("ROB_DEPTH must be at least 2");
   end
   if (MSHR_CNT < 1) begin : g_bad_mshr
      $error("MSHR_CNT must be at least 1");
   end
   if (ACC_W <= WAIT_W + 1) begin : g_bad_acc
      $error("ACC_W must exceed WAIT_W + 1");
   end

   logic             blocked;
   logic             head_marked;
   logic             drain_now;
   logic [WAIT_W-1:0] buf_val;
   logic             live_pulse;

   assign blocked   = rob_full | iq_full | regs_out;
   assign drain_now = blocked & head_miss;

   rsc_mark_array #(.DEPTH(ROB_DEPTH)) u_marks (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (mark_set),
      .set_idx    (mark_idx),
      .retire_en  (head_commit),
      .retire_idx (head_idx),
      .flush      (squash_all),
      .rd_idx     (head_idx),
      .rd_bit     (head_marked)
   );

   rsc_wait_bank #(
      .ENTRIES  (MSHR_CNT),
      .CNT_W    (WAIT_W),
      .SATURATE (WAIT_SAT)
   ) u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .pulse       (wait_pulse),
      .alloc_en    (mshr_alloc),
      .alloc_id    (mshr_alloc_id),
      .free_en     (mshr_free),
      .free_id     (mshr_free_id),
      .drain_en    (drain_now),
      .drain_id    (head_mshr),
      .drain_val   (buf_val),
      .drain_pulse (live_pulse)
   );

   rsc_charge_accum #(.ACC_W(ACC_W), .CNT_W(WAIT_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (sw_clear),
      .pen_step   (blocked & head_marked),
      .tot_en     (drain_now),
      .buf_val    (buf_val),
      .live_pulse (live_pulse),
      .pf_step    (head_pf_hit),
      .total      (total_cycles),
      .penalty    (marked_cycles)
   );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
   parameter int unsigned ACC_W = 32,
   parameter int unsigned WAIT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rob_full,
   input logic             iq_full,
   input logic             regs_out,
   input logic             head_miss,
   input logic             sw_clear,
   input logic [ACC_W-1:0] total_cycles,
   input logic [ACC_W-1:0] marked_cycles
);
   logic blk;
   assign blk = rob_full | iq_full | regs_out;

   assert_pen_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk && !sw_clear) |=> marked_cycles == $past(marked_cycles));

   assert_pen_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_clear |=> (marked_cycles - $past(marked_cycles)) <= ACC_W'(1));

   assert_tot_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((!blk || !head_miss) && !sw_clear) |=> total_cycles == $past(total_cycles));

   assert_tot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_clear |=> (total_cycles - $past(total_cycles)) <= ACC_W'((1 << WAIT_W) + 1));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear |=> (total_cycles == '0 && marked_cycles == '0));
endmodule

bind rob_stall_charge rsc_checker #(.ACC_W(ACC_W), .WAIT_W(WAIT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rob_full      (rob_full),
   .iq_full       (iq_full),
   .regs_out      (regs_out),
   .head_miss     (head_miss),
   .sw_clear      (sw_clear),
   .total_cycles  (total_cycles),
   .marked_cycles (marked_cycles)
);

// File: tb/sim_rob_stall_charge.sv
`timescale 1ns/1ps
module sim_rob_stall_charge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rob_full, iq_full, regs_out;
   logic [6:0]  head_idx;
   logic        head_miss;
   logic [4:0]  head_mshr;
   logic        head_pf_hit, head_commit, squash_all, mark_set;
   logic [6:0]  mark_idx;
   logic        mshr_alloc, mshr_free;
   logic [4:0]  mshr_alloc_id, mshr_free_id;
   logic [31:0] wait_pulse;
   logic        sw_clear;
   logic [31:0] total_cycles, marked_cycles;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rob_stall_charge u0 (.*);

   typedef struct packed {
      logic [2:0]  stl;
      logic [6:0]  hd;
      logic        ms;
      logic [4:0]  mid;
      logic        pf;
      logic        mset;
      logic [6:0]  midx;
      logic        pv;
      logic [4:0]  pid;
      logic [15:0] et;
      logic [15:0] ep;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{3'b000, 7'd0, 1'b0, 5'd0, 1'b0, 1'b1, 7'd5, 1'b0, 5'd0, 16'd0, 16'd0},
      '{3'b000, 7'd0, 1'b0, 5'd0, 1'b0, 1'b0, 7'd0, 1'b1, 5'd2, 16'd0, 16'd0},
      '{3'b000, 7'd0, 1'b0, 5'd0, 1'b0, 1'b0, 7'd0, 1'b1, 5'd2, 16'd0, 16'd0},
      '{3'b100, 7'd5, 1'b1, 5'd2, 1'b0, 1'b0, 7'd0, 1'b0, 5'd0, 16'd2, 16'd1},
      '{3'b100, 7'd5, 1'b1, 5'd2, 1'b0, 1'b0, 7'd0, 1'b1, 5'd2, 16'd3, 16'd2},
      '{3'b100, 7'd5, 1'b1, 5'd2, 1'b0, 1'b0, 7'd0, 1'b0, 5'd0, 16'd3, 16'd3},
      '{3'b010, 7'd5, 1'b1, 5'd2, 1'b1, 1'b0, 7'd0, 1'b0, 5'd0, 16'd4, 16'd4},
      '{3'b001, 7'd9, 1'b1, 5'd2, 1'b0, 1'b0, 7'd0, 1'b0, 5'd0, 16'd4, 16'd4},
      '{3'b000, 7'd5, 1'b1, 5'd2, 1'b0, 1'b0, 7'd0, 1'b0, 5'd0, 16'd4, 16'd4},
      '{3'b000, 7'd0, 1'b0, 5'd0, 1'b0, 1'b0, 7'd0, 1'b1, 5'd7, 16'd4, 16'd4},
      '{3'b000, 7'd9, 1'b1, 5'd7, 1'b1, 1'b0, 7'd0, 1'b0, 5'd0, 16'd4, 16'd4},
      '{3'b100, 7'd9, 1'b1, 5'd7, 1'b0, 1'b0, 7'd0, 1'b0, 5'd0, 16'd5, 16'd4}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic idle();
      rob_full = 0; iq_full = 0; regs_out = 0;
      head_idx = '0; head_miss = 0; head_mshr = '0; head_pf_hit = 0;
      head_commit = 0; squash_all = 0; mark_set = 0; mark_idx = '0;
      mshr_alloc = 0; mshr_alloc_id = '0; mshr_free = 0; mshr_free_id = '0;
      wait_pulse = '0; sw_clear = 0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic stall_on(input logic [6:0] hd, input logic miss, input logic [4:0] id);
      idle();
      rob_full = 1; head_idx = hd; head_miss = miss; head_mshr = id;
      tick();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] t0, p0;
      idle();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 reset total", total_cycles, 32'd0);
      chk("R1 reset marked", marked_cycles, 32'd0);

      // R2 R4 R5 R6 R8 vector walk
      for (int i = 0; i < NV; i++) begin
         idle();
         {rob_full, iq_full, regs_out} = TBL[i].stl;
         head_idx = TBL[i].hd; head_miss = TBL[i].ms; head_mshr = TBL[i].mid;
         head_pf_hit = TBL[i].pf; mark_set = TBL[i].mset; mark_idx = TBL[i].midx;
         if (TBL[i].pv) wait_pulse[TBL[i].pid] = 1'b1;
         tick();
         chk($sformatf("R5/R6/R8 vector %0d total", i), total_cycles, 32'(TBL[i].et));
         chk($sformatf("R2 vector %0d marked", i), marked_cycles, 32'(TBL[i].ep));
      end

      // R9: clear beats a same-cycle charge on a marked blocked head
      idle();
      rob_full = 1; head_idx = 7'd5; head_miss = 1; head_pf_hit = 1; sw_clear = 1;
      tick();
      chk("R9 clear total", total_cycles, 32'd0);
      chk("R9 clear marked", marked_cycles, 32'd0);

      // R3: commit clears mark
      idle(); mark_set = 1; mark_idx = 7'd20; tick();
      idle(); head_idx = 7'd20; head_commit = 1; tick();
      p0 = marked_cycles;
      stall_on(7'd20, 1'b0, 5'd0);
      chk("R3 commit cleared mark", marked_cycles, p0);
      idle(); mark_set = 1; mark_idx = 7'd21; tick();
      p0 = marked_cycles;
      stall_on(7'd21, 1'b0, 5'd0);
      chk("R3 set mark counts", marked_cycles, p0 + 1);

      // R3: flush clears all marks, and wins over a same-cycle set
      idle(); mark_set = 1; mark_idx = 7'd30; tick();
      idle(); squash_all = 1; mark_set = 1; mark_idx = 7'd31; tick();
      p0 = marked_cycles;
      stall_on(7'd30, 1'b0, 5'd0);
      stall_on(7'd31, 1'b0, 5'd0);
      chk("R3 flush cleared marks", marked_cycles, p0);

      // R7: free discards buffered cycles
      for (int k = 0; k < 3; k++) begin idle(); wait_pulse[4] = 1; tick(); end
      idle(); mshr_free = 1; mshr_free_id = 5'd4; tick();
      t0 = total_cycles;
      stall_on(7'd40, 1'b1, 5'd4);
      chk("R7 free discards", total_cycles, t0);

      // R7: allocate discards buffered cycles
      for (int k = 0; k < 2; k++) begin idle(); wait_pulse[6] = 1; tick(); end
      idle(); mshr_alloc = 1; mshr_alloc_id = 5'd6; tick();
      t0 = total_cycles;
      stall_on(7'd41, 1'b1, 5'd6);
      chk("R7 alloc discards", total_cycles, t0);

      // R4: saturation at 1023
      for (int k = 0; k < 1030; k++) begin idle(); wait_pulse[1] = 1; tick(); end
      t0 = total_cycles;
      stall_on(7'd42, 1'b1, 5'd1);
      chk("R4 saturate 1023", total_cycles, t0 + 32'd1023);
      stall_on(7'd42, 1'b1, 5'd1);
      chk("R5 charged once", total_cycles, t0 + 32'd1023);

      idle();
      tick();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule